// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two levels of a page table held in external memory. The logical address is cut into three fields: the top 10 bits pick an entry in a directory page, the next 10 bits pick an entry in the inner table that the directory entry points to, and the low 12 bits are the byte offset inside a 4 KB page. Every table entry is one 32-bit word, so a table of 1024 entries fills exactly one page. The physical address is the frame number from the inner entry joined with the untouched offset.

Both entries carry a valid flag and three access flags (read, write, execute). The walker checks the flags of each entry against the request type as soon as that entry's data returns, in the same step that forms the next address. A missing page and a disallowed access come back as two different fault codes, and the physical address is then zero. A fault found in the directory entry ends the walk at once, so the inner entry is never fetched.

Requests arrive through a valid/ready handshake. Memory is reached through a single-outstanding read port with a one-cycle request strobe and any response latency. The result appears as a one-cycle response pulse.

Top module: `pt_walker`

## Requirements
- R1: Synchronous active-high reset, even in the middle of a walk, leaves `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0, and no response follows.
- R2: After a request is accepted, the first memory read goes to the directory entry at `{root_frame, vaddr[31:22], 2'b00}`.
- R3: When the directory entry passes its checks, the second read goes to `{dir_entry[31:12], vaddr[21:12], 2'b00}`, and no further read is made for that request.
- R4: When both entries pass, the response has fault code 0 and `rsp_paddr = {leaf_entry[31:12], vaddr[11:0]}`.
- R5: An entry whose bit 0 (valid) is clear gives fault code 1 (invalid), whatever its other bits are; this test comes before the permission test.
- R6: For a valid entry, a request of kind 0 (read) needs bit 1, kind 1 (write) needs bit 2, and kind 2 (execute) needs bit 3. If the needed bit is clear, the fault code is 2 (protection). Kind 3 always gives fault code 2.
- R7: A fault found in the directory entry ends the walk after exactly one memory read.
- R8: At most one memory read is outstanding at any time. The walker waits for as many cycles as the memory takes to answer.
- R9: `req_ready` is low from acceptance until the response is presented. A request offered while busy is ignored. `rsp_valid` lasts one cycle.
- R10: Whenever the fault code is not 0, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_frame | input | 20 | Frame number of the directory page |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle strobe marking the result |
| rsp_paddr | output | 32 | Physical address; zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 protection |
| mem_req_valid | output | 1 | One-cycle memory read strobe |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry returned by memory |

## Verification
On every cycle, the assertions check these properties: the one-read-in-flight limit, the one-cycle response pulse, that the walker is busy after acceptance, that a fault forces a zero address, that the offset passes through unchanged on success, and that a directory fault stops the walk without a second read. Only the bench scenarios can show which entry address is read at each level and which fault code each combination of flags and access type produces. The same holds for busy-time requests being ignored, for different memory latencies, and for recovery from a reset in the middle of a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    WS_IDLE      = 2'd0,
    WS_DIR_WAIT  = 2'd1,
    WS_LEAF_WAIT = 2'd2
  } walk_state_e;

  // flag positions inside an entry
  localparam int FLG_VALID = 0;
  localparam int FLG_RD    = 1;
  localparam int FLG_WR    = 2;
  localparam int FLG_EX    = 3;
  localparam int FLG_W     = 4;

endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
(
  input  logic [FLG_W-1:0] flags,
  input  logic [1:0]       kind,
  output logic [1:0]       fault
);

  logic need_ok;

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_READ:  need_ok = flags[FLG_RD];
      ACC_WRITE: need_ok = flags[FLG_WR];
      ACC_EXEC:  need_ok = flags[FLG_EX];
      default:   need_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!flags[FLG_VALID])  fault = FLT_INVALID;
    else if (!need_ok)      fault = FLT_PROT;
    else                    fault = FLT_NONE;
  end

endmodule

// File: rtl/pt_addr_form.sv
module pt_addr_form #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OUT_W  = 10,
  parameter int IN_W   = 10,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2,
  localparam int FRM_W = PA_W - OFF_W
) (
  input  logic [VA_W-1:0]  new_va,
  input  logic [VA_W-1:0]  held_va,
  input  logic [FRM_W-1:0] root_frame,
  input  logic [FRM_W-1:0] ent_frame,
  output logic [PA_W-1:0]  dir_addr,
  output logic [PA_W-1:0]  leaf_addr,
  output logic [PA_W-1:0]  phys_addr
);

  logic [OUT_W-1:0] out_idx;
  logic [IN_W-1:0]  in_idx;
  logic [OFF_W-1:0] offs;
  logic             va_spare_unused;
  logic             new_va_low_unused;

  assign out_idx = new_va[VA_W-1 -: OUT_W];
  assign in_idx  = held_va[OFF_W+IN_W-1 -: IN_W];
  assign offs    = held_va[OFF_W-1:0];
  assign va_spare_unused   = ^held_va[VA_W-1:OFF_W+IN_W];
  assign new_va_low_unused = ^new_va[VA_W-OUT_W-1:0];

  assign dir_addr  = {root_frame, {OFF_W{1'b0}}} | (PA_W'(out_idx) << ENT_LG);
  assign leaf_addr = {ent_frame,  {OFF_W{1'b0}}} | (PA_W'(in_idx)  << ENT_LG);
  assign phys_addr = {ent_frame, offs};

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  output logic [VA_W-1:0] va_q,
  output logic [1:0]      kind_q,
  input  logic [1:0]      lvl_fault,
  input  logic [PA_W-1:0] dir_addr,
  input  logic [PA_W-1:0] leaf_addr,
  input  logic [PA_W-1:0] phys_addr,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault
);

  walk_state_e state;
  logic        rd_open_q;

  assign req_ready = (state == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= WS_IDLE;
      va_q          <= '0;
      kind_q        <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_fault     <= FLT_NONE;
    end else begin
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (req_valid) begin
            va_q          <= req_vaddr;
            kind_q        <= req_kind;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= dir_addr;
            state         <= WS_DIR_WAIT;
          end
        end
        WS_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            if (lvl_fault != FLT_NONE) begin
              rsp_valid <= 1'b1;
              rsp_fault <= lvl_fault;
              rsp_paddr <= '0;
              state     <= WS_IDLE;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= leaf_addr;
              state         <= WS_LEAF_WAIT;
            end
          end
        end
        WS_LEAF_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= lvl_fault;
            rsp_paddr <= (lvl_fault == FLT_NONE) ? phys_addr : '0;
            state     <= WS_IDLE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  // tracks a memory read that has been issued and not yet answered
  always_ff @(posedge clk) begin
    if (rst)                rd_open_q <= 1'b0;
    else if (mem_req_valid) rd_open_q <= 1'b1;
    else if (mem_rsp_valid) rd_open_q <= 1'b0;
  end

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !rd_open_q);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7
  dir_fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == WS_DIR_WAIT && mem_rsp_valid && lvl_fault != FLT_NONE)
      |=> (rsp_valid && !mem_req_valid));

  // R10
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OUT_W = 10,
  parameter int IN_W  = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32,
  localparam int VA_W   = OUT_W + IN_W + OFF_W,
  localparam int FRM_W  = PA_W - OFF_W,
  localparam int ENT_LG = $clog2(PTE_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FRM_W-1:0] root_frame,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);

  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic [1:0]       lvl_fault;
  logic [PA_W-1:0]  dir_addr;
  logic [PA_W-1:0]  leaf_addr;
  logic [PA_W-1:0]  phys_addr;
  logic [FRM_W-1:0] ent_frame;
  logic             pte_spare_unused;

  assign ent_frame        = mem_rsp_data[PTE_W-1 -: FRM_W];
  assign pte_spare_unused = ^mem_rsp_data[PTE_W-FRM_W-1:FLG_W];

  pt_entry_check u_check (
    .flags (mem_rsp_data[FLG_W-1:0]),
    .kind  (kind_q),
    .fault (lvl_fault)
  );

  pt_addr_form #(
    .VA_W(VA_W), .PA_W(PA_W), .OUT_W(OUT_W), .IN_W(IN_W),
    .OFF_W(OFF_W), .ENT_LG(ENT_LG)
  ) u_addr (
    .new_va     (req_vaddr),
    .held_va    (va_q),
    .root_frame (root_frame),
    .ent_frame  (ent_frame),
    .dir_addr   (dir_addr),
    .leaf_addr  (leaf_addr),
    .phys_addr  (phys_addr)
  );

  pt_walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .va_q          (va_q),
    .kind_q        (kind_q),
    .lvl_fault     (lvl_fault),
    .dir_addr      (dir_addr),
    .leaf_addr     (leaf_addr),
    .phys_addr     (phys_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
  );

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] root_frame = 20'h00001;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int checks = 0;
  int errors = 0;
  int mem_lat = 0;

  always #10 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model: 16 KB, variable latency, logs every read
  logic [31:0] mem [0:4095];
  logic [31:0] rd_log [0:63];
  int          rd_cnt = 0;
  logic        pend = 1'b0;
  logic        overlap = 1'b0;
  int          cnt = 0;
  logic [31:0] addr_q = '0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
      mem_rsp_data <= '0;
    end else if (mem_req_valid) begin
      if (pend) overlap <= 1'b1;
      rd_log[rd_cnt[5:0]] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
      pend   <= 1'b1;
      cnt    <= mem_lat;
      addr_q <= mem_req_addr;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[addr_q[13:2]];
        pend          <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {vaddr, kind, exp_fault, exp_paddr, exp_reads}
  localparam int NV = 16;
  localparam logic [69:0] VEC [0:NV-1] = '{
    {32'h00000ABC, 2'd0, 2'd0, 32'h12345ABC, 2'd2},
    {32'h00000004, 2'd1, 2'd0, 32'h12345004, 2'd2},
    {32'h00000FFF, 2'd2, 2'd0, 32'h12345FFF, 2'd2},
    {32'h00001010, 2'd0, 2'd0, 32'hABCDE010, 2'd2},
    {32'h00001000, 2'd1, 2'd2, 32'h00000000, 2'd2},
    {32'h00001020, 2'd2, 2'd2, 32'h00000000, 2'd2},
    {32'h00002123, 2'd2, 2'd0, 32'h00777123, 2'd2},
    {32'h00002000, 2'd0, 2'd2, 32'h00000000, 2'd2},
    {32'h00003000, 2'd0, 2'd1, 32'h00000000, 2'd2},
    {32'h00005800, 2'd1, 2'd0, 32'h0BEEF800, 2'd2},
    {32'h00005000, 2'd0, 2'd2, 32'h00000000, 2'd2},
    {32'h00400044, 2'd0, 2'd0, 32'h0CAFE044, 2'd2},
    {32'h00400000, 2'd1, 2'd2, 32'h00000000, 2'd1},
    {32'h00800000, 2'd0, 2'd1, 32'h00000000, 2'd1},
    {32'h00000000, 2'd3, 2'd2, 32'h00000000, 2'd1},
    {32'h01400000, 2'd1, 2'd1, 32'h00000000, 2'd1}
  };

  task automatic start_req(input logic [31:0] va, input logic [1:0] kd);
    @(negedge clk);
    req_vaddr = va; req_kind = kd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_req(input int base, input logic [31:0] va, input logic [1:0] ef,
                            input logic [31:0] ep, input int enr);
    int n = 0;
    logic [31:0] e_dir, e_leaf;
    string tg;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, "R8 response wait", 32'(n), 32'd0);
    tg = (ef == 2'd0) ? "R4 fault" : (ef == 2'd1) ? "R5 invalid" : "R6 protection";
    chk(rsp_fault == ef, tg, 32'(rsp_fault), 32'(ef));
    chk(rsp_paddr == ep, (ef == 2'd0) ? "R4 paddr" : "R10 paddr", rsp_paddr, ep);
    chk(rd_cnt - base == enr, (enr == 1) ? "R7 read count" : "R3 read count",
        32'(rd_cnt - base), 32'(enr));
    e_dir = 32'h00001000 | ({22'd0, va[31:22]} << 2);
    chk(rd_log[base[5:0]] == e_dir, "R2 directory address", rd_log[base[5:0]], e_dir);
    if (enr == 2) begin
      e_leaf = {mem[e_dir[13:2]][31:12], 12'h000} | ({22'd0, va[21:12]} << 2);
      chk(rd_log[6'(base + 1)] == e_leaf, "R3 inner address", rd_log[6'(base + 1)], e_leaf);
    end
    chk(req_ready == 1'b1, "R9 ready at response", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response pulse", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // directory at frame 1 (word 1024 + outer)
    mem[1024 + 0] = 32'h0000200F;
    mem[1024 + 1] = 32'h00003003;
    mem[1024 + 2] = 32'h0000300E;
    // inner table at frame 2
    mem[2048 + 0] = 32'h1234500F;
    mem[2048 + 1] = 32'hABCDE003;
    mem[2048 + 2] = 32'h00777009;
    mem[2048 + 3] = 32'h5555500E;
    mem[2048 + 5] = 32'h0BEEF005;
    // inner table at frame 3
    mem[3072 + 0] = 32'h0CAFE00F;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      int base;
      mem_lat = v % 4;
      base = rd_cnt;
      start_req(VEC[v][69:38], VEC[v][37:36]);
      finish_req(base, VEC[v][69:38], VEC[v][35:34], VEC[v][33:2], int'(VEC[v][1:0]));
    end

    // R9: request offered while busy is ignored
    begin
      int base;
      mem_lat = 5;
      base = rd_cnt;
      start_req(32'h00000ABC, 2'd0);
      req_vaddr = 32'h00800000; req_kind = 2'd1; req_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        chk(req_ready == 1'b0, "R9 busy ready", 32'(req_ready), 32'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      finish_req(base, 32'h00000ABC, 2'd0, 32'h12345ABC, 2);
      repeat (20) @(negedge clk);
      chk(rd_cnt - base == 2, "R9 ignored request made no read", 32'(rd_cnt - base), 32'd2);
    end

    // R8 long latency and overlap
    begin
      int base;
      mem_lat = 40;
      base = rd_cnt;
      start_req(32'h00400044, 2'd0);
      finish_req(base, 32'h00400044, 2'd0, 32'h0CAFE044, 2);
      chk(overlap == 1'b0, "R8 single outstanding", 32'(overlap), 32'd0);
    end

    // R1 reset in the middle of a walk
    begin
      mem_lat = 6;
      start_req(32'h00000ABC, 2'd0);
      repeat (2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(req_ready == 1'b1, "R1 ready after mid-walk reset", 32'(req_ready), 32'd1);
      begin
        logic seen = 1'b0;
        for (int k = 0; k < 30; k++) begin
          if (rsp_valid) seen = 1'b1;
          @(negedge clk);
        end
        chk(seen == 1'b0, "R1 no response after reset", 32'(seen), 32'd0);
      end
      mem_lat = 1;
      begin
        int base;
        base = rd_cnt;
        start_req(32'h00002123, 2'd2);
        finish_req(base, 32'h00002123, 2'd0, 32'h00777123, 2);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule